// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Detector

This block guards an I2C target interface that may run under SMBus rules. It watches an already synchronized copy of the serial clock line. When the clock is held low for 30 ms while the interface is actually in a transfer, the block raises a sticky timeout flag. Firmware then resets the target interface. The block does not perform that reset itself; the reset is left to whatever consumes the flag. An interrupt line follows the flag, gated by an enable from the register side.

The elapsed time is measured in clock cycles of the block's own clock. The cycle budget is derived from two parameters: the clock frequency and the timeout length in microseconds. Counting only proceeds while every qualifying condition holds at the same time. If any one of them fails, the count returns to zero. Once the budget is used up, the counter stays pinned until the low period ends, so each low period produces at most one timeout event.

Top module: `smbto_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `timeout_flag_o` and `irq_o` are 0.
- R2: With all qualifying conditions true, `timeout_flag_o` becomes 1 right after the LIMIT-th consecutive rising clock edge at which they were sampled true, and not after the (LIMIT-1)-th.
- R3: While `tgt_idle_i` is 1, the cycle count stays at zero and no timeout is raised.
- R4: While `smb_mode_i` is 0, the cycle count stays at zero and no timeout is raised.
- R5: While `scl_i` is 1, the cycle count stays at zero and no timeout is raised.
- R6: While `if_enable_i` is 0, the cycle count stays at zero and no timeout is raised.
- R7: When any qualifying condition is false for even one sampled edge, the count restarts from zero instead of resuming.
- R8: Once set, `timeout_flag_o` stays 1 until `flag_clr_i` is sampled 1 at a rising edge, after which it reads 0.
- R9: If a timeout fires at the same edge where `flag_clr_i` is 1, the flag ends up set.
- R10: `irq_o` equals `timeout_flag_o` AND `irq_en_i` at all times, with no register in between.
- R11: After a timeout fires, the counter holds at LIMIT and fires no further event while the same low period lasts; clearing the flag during that period leaves it clear.
- R12: LIMIT equals CLK_FREQ_HZ × TIMEOUT_US / 1,000,000, rounded down and never below 1; the defaults give 30 ms at 100 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock level |
| tgt_idle_i | input | 1 | Target interface idle, no bus activity |
| smb_mode_i | input | 1 | SMBus timing mode enabled |
| if_enable_i | input | 1 | Target interface enabled |
| flag_clr_i | input | 1 | Clear request for the timeout flag |
| irq_en_i | input | 1 | Interrupt enable |
| timeout_flag_o | output | 1 | Sticky timeout status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with CLK_FREQ_HZ = 1000 and the default TIMEOUT_US = 30000. That gives a budget of 30 cycles, which still corresponds to 30 ms of real time at that clock. With so short a budget, the exact firing edge, a restart after a one-cycle break, and the behaviour of the counter while it is pinned at its limit can all be observed directly. The bench can also hold the condition for several times the budget to show that no second event follows. The same arithmetic produces the multi-million-cycle budget at the default frequency.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

    // Cycle budget from clock frequency and timeout length; at least 1.
    function automatic int unsigned calc_limit(input int unsigned freq_hz,
                                               input int unsigned span_us);
        longint unsigned prod;
        prod = (longint'(freq_hz) * longint'(span_us)) / 64'd1_000_000;
        if (prod == 0) prod = 1;
        return int'(prod);
    endfunction

    // Individual qualifying terms, all active high.
    typedef struct packed {
        logic busy;      // target not idle
        logic smb_on;    // SMBus mode selected
        logic clk_low;   // serial clock low
        logic enabled;   // interface enabled
    } smbto_qual_t;

    typedef enum logic [1:0] {
        TMR_REST    = 2'd0,
        TMR_COUNT   = 2'd1,
        TMR_EXPIRED = 2'd2
    } smbto_state_e;

endpackage

// File: rtl/smbto_qualify.sv
module smbto_qualify
    import smbto_pkg::*;
(
    input  logic        scl_i,
    input  logic        tgt_idle_i,
    input  logic        smb_mode_i,
    input  logic        if_enable_i,
    output smbto_qual_t qual_o,
    output logic        run_o
);
    always_comb begin
        qual_o.busy    = ~tgt_idle_i;
        qual_o.smb_on  = smb_mode_i;
        qual_o.clk_low = ~scl_i;
        qual_o.enabled = if_enable_i;
    end

    // Every term must hold at once.
    assign run_o = &qual_o;
endmodule

// File: rtl/smbto_counter.sv
module smbto_counter
    import smbto_pkg::*;
#(
    parameter int unsigned LIMIT = 30,
    parameter int          CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o,
    output logic          fire_o
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    smbto_state_e  state_q;
    logic [CW-1:0] cnt_q;

    assign fire_o = run_i && (state_q != TMR_EXPIRED) && (cnt_q == LAST);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q   <= '0;
            state_q <= TMR_REST;
        end else begin
            case (state_q)
                TMR_REST, TMR_COUNT: begin
                    if (cnt_q == LAST) begin
                        cnt_q   <= TOP;
                        state_q <= TMR_EXPIRED;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= TMR_COUNT;
                    end
                end
                default: begin
                    cnt_q   <= TOP;
                    state_q <= TMR_EXPIRED;
                end
            endcase
        end
    end
endmodule

// File: rtl/smbto_flag.sv
module smbto_flag (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Set takes priority over clear.
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (fire_i) flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/smbto_timer.sv
module smbto_timer
    import smbto_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 100_000_000,
    parameter int unsigned TIMEOUT_US  = 30_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic tgt_idle_i,
    input  logic smb_mode_i,
    input  logic if_enable_i,
    input  logic flag_clr_i,
    input  logic irq_en_i,
    output logic timeout_flag_o,
    output logic irq_o
);
    localparam int unsigned LIMIT = calc_limit(CLK_FREQ_HZ, TIMEOUT_US);
    localparam int          CW    = $clog2(LIMIT + 1);

    smbto_qual_t   qual;
    logic          run;
    logic [CW-1:0] cnt;
    logic          fire;

    smbto_qualify u_qual (
        .scl_i       (scl_i),
        .tgt_idle_i  (tgt_idle_i),
        .smb_mode_i  (smb_mode_i),
        .if_enable_i (if_enable_i),
        .qual_o      (qual),
        .run_o       (run)
    );

    smbto_counter #(.LIMIT(LIMIT), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .cnt_o  (cnt),
        .fire_o (fire)
    );

    smbto_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (fire),
        .clr_i    (flag_clr_i),
        .irq_en_i (irq_en_i),
        .flag_o   (timeout_flag_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/smbto_checker.sv
module smbto_checker #(
    parameter int unsigned LIMIT = 30,
    parameter int          CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input logic          tgt_idle_i,
    input logic          smb_mode_i,
    input logic          if_enable_i,
    input logic          flag_clr_i,
    input logic          irq_en_i,
    input logic          timeout_flag_o,
    input logic          irq_o,
    input logic [CW-1:0] cnt
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!timeout_flag_o && cnt == '0));

    assert_fire_point_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag_o) |-> ($past(cnt) == CW'(LIMIT - 1)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        tgt_idle_i |=> (cnt == '0));

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !smb_mode_i |=> (cnt == '0));

    assert_scl_hold_R5: assert property (@(posedge clk) disable iff (rst)
        scl_i |=> (cnt == '0));

    assert_enable_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !if_enable_i |=> (cnt == '0));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag_o && !flag_clr_i) |=> timeout_flag_o);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o == (timeout_flag_o && irq_en_i));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));

    assert_single_event_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(LIMIT) && flag_clr_i) |=> !timeout_flag_o);
endmodule

bind smbto_timer smbto_checker #(.LIMIT(LIMIT), .CW(CW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .scl_i          (scl_i),
    .tgt_idle_i     (tgt_idle_i),
    .smb_mode_i     (smb_mode_i),
    .if_enable_i    (if_enable_i),
    .flag_clr_i     (flag_clr_i),
    .irq_en_i       (irq_en_i),
    .timeout_flag_o (timeout_flag_o),
    .irq_o          (irq_o),
    .cnt            (cnt)
);

// File: tb/smbto_timer_tb.sv
module smbto_timer_tb;
    localparam int unsigned FREQ = 1000;
    localparam int unsigned SPAN = 30_000;
    localparam int          L    = 30;   // 1000 * 30000 / 1e6 (R12)

    typedef struct {
        logic  flag;
        logic  irq;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, idle = 1'b1, smb = 1'b0, en = 1'b0, clr = 1'b0, irq_en = 1'b0;
    logic flag, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t q[$];
    event chk_ev;

    always #5 clk = ~clk;

    smbto_timer #(.CLK_FREQ_HZ(FREQ), .TIMEOUT_US(SPAN)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .tgt_idle_i(idle),
        .smb_mode_i(smb), .if_enable_i(en), .flag_clr_i(clr),
        .irq_en_i(irq_en), .timeout_flag_o(flag), .irq_o(irq)
    );

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (flag !== e.flag || irq !== e.irq) begin
                    fails++;
                    $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b",
                             e.tag, flag, irq, e.flag, e.irq);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input logic f, input logic i, input string tag);
        exp_t e;
        #1;
        e.flag = f; e.irq = i; e.tag = tag;
        q.push_back(e);
        ->chk_ev;
        #1;
    endtask

    task automatic qualify();
        scl = 1'b0; idle = 1'b0; smb = 1'b1; en = 1'b1;
    endtask

    task automatic clear_flag();
        scl = 1'b1;
        clr = 1'b1;
        step(1);
        clr = 1'b0;
    endtask

    // which: 3 idle, 4 mode off, 5 scl high, 6 disabled
    task automatic blocked_case(input int which, input string tag);
        qualify();
        case (which)
            3: idle = 1'b1;
            4: smb  = 1'b0;
            5: scl  = 1'b1;
            default: en = 1'b0;
        endcase
        step(2 * L);
        expect_out(1'b0, 1'b0, tag);
        qualify();
        step(L - 1);
        expect_out(1'b0, 1'b0, tag);
        step(1);
        expect_out(1'b1, 1'b0, tag);
        clear_flag();
        expect_out(1'b0, 1'b0, tag);
    endtask

    initial begin
        step(3);
        expect_out(1'b0, 1'b0, "R1 in reset");
        rst = 1'b0;
        step(1);
        expect_out(1'b0, 1'b0, "R1 after reset");

        // R2 / R12: exact firing edge
        qualify();
        step(L - 1);
        expect_out(1'b0, 1'b0, "R2 one edge early");
        step(1);
        expect_out(1'b1, 1'b0, "R2 R12 fires at LIMIT");

        // R10: interrupt gating
        irq_en = 1'b1;
        expect_out(1'b1, 1'b1, "R10 irq enabled");
        irq_en = 1'b0;
        expect_out(1'b1, 1'b0, "R10 irq masked");
        irq_en = 1'b1;

        // R8: sticky
        step(10);
        expect_out(1'b1, 1'b1, "R8 sticky");

        // R11: clear while still low, no refire
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        expect_out(1'b0, 1'b0, "R8 cleared");
        step(2 * L);
        expect_out(1'b0, 1'b0, "R11 no second event");

        // R7: restart after a one-cycle break
        scl = 1'b1;
        step(1);
        scl = 1'b0;
        step(L - 1);
        scl = 1'b1;
        step(1);
        scl = 1'b0;
        step(L - 1);
        expect_out(1'b0, 1'b0, "R7 count restarted");
        step(1);
        expect_out(1'b1, 1'b1, "R7 fires after full budget");
        clear_flag();
        expect_out(1'b0, 1'b0, "R7 cleanup");

        irq_en = 1'b0;
        blocked_case(3, "R3 idle blocks");
        blocked_case(4, "R4 mode off blocks");
        blocked_case(5, "R5 scl high blocks");
        blocked_case(6, "R6 disabled blocks");

        // R9: set beats clear
        qualify();
        step(L - 1);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        expect_out(1'b1, 1'b0, "R9 set wins over clear");

        // R1: reset clears a set flag
        rst = 1'b1;
        step(1);
        expect_out(1'b0, 1'b0, "R1 reset clears flag");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #500_000;
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule